// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and presents them to a processor on two lines: an ordinary interrupt line and a fast interrupt line. Every source carries three bits of state: a pending bit that mirrors its request input one clock late, an enable bit, and a routing bit. The routing bit selects the fast line when it is 1 and the ordinary line when it is 0. A source reaches its chosen line only while both its pending bit and its enable bit are set.

Software reaches the block over a small word-addressed register bus. Writes take effect on the clock edge at which `bus_we` is high. Read data is combinational from the addressed state. Software can read a masked pending view for each line, the raw pending word, the enable mask, the routing mask and an idle-control flag. It can write the enable mask, the routing mask and the idle flag. Priority resolution, vectoring and edge capture are left to the surrounding system.

Top module: `irqc_top`

## Requirements
- R1: After each clock edge, the raw pending word, read at offset 0, equals the request inputs sampled at that edge. A request that drops clears its pending bit at the next edge, with no latching.
- R2: `irq_fast` is 1 exactly when some source has its pending, enable and routing bits all set.
- R3: `irq_normal` is 1 exactly when some source has its pending and enable bits set and its routing bit clear.
- R4: Offset 3 reads pending AND enable AND NOT routing. Offset 4 reads pending AND enable AND routing.
- R5: The enable mask (offset 1) and the routing mask (offset 2) are written in full by a bus write and read back unchanged.
- R6: A write to offset 5 makes the idle flag equal to bit 0 of the write data. A read of offset 5 returns the flag in bit 0 and zero in every other bit.
- R7: A write to the enable or routing mask changes neither output before the write edge. Both outputs reflect the new mask right after that edge, together with any request change sampled on the same edge.
- R8: Reset clears the enable mask, the routing mask, the idle flag and the pending word, so both outputs are 0.
- R9: Reads of offsets 6 and 7 return zero. Writes to offsets 0, 3, 4, 6 and 7 leave the enable mask, the routing mask and the idle flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Level-sensitive request inputs, one per source |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` |
| irq_normal | output | 1 | Ordinary interrupt line to the processor |
| irq_fast | output | 1 | Fast interrupt line to the processor |

## Verification
A change on a request input and a write to the enable or routing mask can land on the same clock edge, and both feed the same pair of outputs. The bench provokes this by raising a request and writing a mask on one edge. It first confirms that neither output moves before the edge. After the edge, it confirms that the outputs combine the new request level with the new mask. A further case moves a source from one line to the other with a single routing write, and the bench judges that one line falls and the other rises in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Word offsets of the register bus.
    localparam int unsigned OFF_RAW       = 0;
    localparam int unsigned OFF_ENABLE    = 1;
    localparam int unsigned OFF_ROUTE     = 2;
    localparam int unsigned OFF_VIEW_NORM = 3;
    localparam int unsigned OFF_VIEW_FAST = 4;
    localparam int unsigned OFF_IDLE      = 5;

    // Output line index used by the routing stage.
    localparam int unsigned LINE_NORM  = 0;
    localparam int unsigned LINE_FAST  = 1;
    localparam int unsigned LINE_COUNT = 2;
endpackage

// File: rtl/irqc_src_stage.sv
module irqc_src_stage #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    output logic [N_SRC-1:0] pend
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } stage_t;

    stage_t stage_d, stage_q;

    // Pending tracks the sampled level; nothing is held once a request drops.
    always_comb begin
        stage_d      = stage_q;
        stage_d.pend = src_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign pend = stage_q.pend;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [N_SRC-1:0]  en,
    output logic [N_SRC-1:0]  route,
    output logic              idle
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] route;
        logic             idle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(OFF_ENABLE)) begin
                ctl_d.en = bus_wdata[N_SRC-1:0];
            end else if (bus_addr == ADDR_W'(OFF_ROUTE)) begin
                ctl_d.route = bus_wdata[N_SRC-1:0];
            end else if (bus_addr == ADDR_W'(OFF_IDLE)) begin
                ctl_d.idle = bus_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en    = ctl_q.en;
    assign route = ctl_q.route;
    assign idle  = ctl_q.idle;
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] route,
    output logic [N_SRC-1:0] view_norm,
    output logic [N_SRC-1:0] view_fast,
    output logic             irq_norm,
    output logic             irq_fast
);
    logic [LINE_COUNT-1:0][N_SRC-1:0] view;
    logic [LINE_COUNT-1:0]            line;

    for (genvar k = 0; k < LINE_COUNT; k++) begin : g_line
        localparam bit SEL_FAST = (k == LINE_FAST);
        always_comb begin
            view[k] = pend & en & (SEL_FAST ? route : ~route);
            line[k] = |view[k];
        end
    end

    assign view_norm = view[LINE_NORM];
    assign view_fast = view[LINE_FAST];
    assign irq_norm  = line[LINE_NORM];
    assign irq_fast  = line[LINE_FAST];
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_normal,
    output logic              irq_fast
);
    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] en_w;
    logic [N_SRC-1:0] route_w;
    logic             idle_w;
    logic [N_SRC-1:0] view_norm_w;
    logic [N_SRC-1:0] view_fast_w;

    irqc_src_stage #(.N_SRC(N_SRC)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .src_in(src_in),
        .pend  (pend_w)
    );

    irqc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .en       (en_w),
        .route    (route_w),
        .idle     (idle_w)
    );

    irqc_route #(.N_SRC(N_SRC)) u_route (
        .pend     (pend_w),
        .en       (en_w),
        .route    (route_w),
        .view_norm(view_norm_w),
        .view_fast(view_fast_w),
        .irq_norm (irq_normal),
        .irq_fast (irq_fast)
    );

    // Read mux: unmapped offsets fall through to zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_RAW))            bus_rdata = DATA_W'(pend_w);
        else if (bus_addr == ADDR_W'(OFF_ENABLE))    bus_rdata = DATA_W'(en_w);
        else if (bus_addr == ADDR_W'(OFF_ROUTE))     bus_rdata = DATA_W'(route_w);
        else if (bus_addr == ADDR_W'(OFF_VIEW_NORM)) bus_rdata = DATA_W'(view_norm_w);
        else if (bus_addr == ADDR_W'(OFF_VIEW_FAST)) bus_rdata = DATA_W'(view_fast_w);
        else if (bus_addr == ADDR_W'(OFF_IDLE))      bus_rdata = DATA_W'(idle_w);
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_in,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_normal,
    input logic              irq_fast,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  en,
    input logic [N_SRC-1:0]  route,
    input logic              idle
);
    logic wr_unmapped;
    assign wr_unmapped = bus_we && (bus_addr > ADDR_W'(OFF_IDLE));

    assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(src_in));

    assert_fast_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in == '0) |=> !irq_fast);

    assert_norm_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in == '0) |=> !irq_normal);

    assert_enable_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_ENABLE) && bus_wdata[N_SRC-1:0] == '0)
        |=> (!irq_fast && !irq_normal));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en == '0 && route == '0 && !idle));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> ($stable(en) && $stable(route) && $stable(idle)));
endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_normal(irq_normal),
    .irq_fast  (irq_fast),
    .pend      (pend_w),
    .en        (en_w),
    .route     (route_w),
    .idle      (idle_w)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam int A_RAW = 0, A_EN = 1, A_RT = 2, A_VN = 3, A_VF = 4, A_IDLE = 5;
    localparam int NVEC = 7;
    // {src, enable, route}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0000_0001, 32'h0000_0001, 32'h8000_0000},
        {32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
        {32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h00FF_00FF},
        {32'h1234_5678, 32'hEDCB_A987, 32'hFFFF_FFFF},
        {32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_normal, irq_fast;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_normal(irq_normal), .irq_fast(irq_fast)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 3'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        src_in = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R8: reset state
        check("R8 irq_normal", 32'(irq_normal), 0);
        check("R8 irq_fast", 32'(irq_fast), 0);
        rd(A_EN, r);   check("R8 enable", r, 0);
        rd(A_RT, r);   check("R8 route", r, 0);
        rd(A_IDLE, r); check("R8 idle", r, 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] s, e, t, vn, vf;
            {s, e, t} = VEC[i];
            vn = s & e & ~t;
            vf = s & e & t;
            wr(A_EN, e);
            wr(A_RT, t);
            set_src(s);
            #1;
            check("R3 irq_normal", 32'(irq_normal), 32'(|vn));
            check("R2 irq_fast", 32'(irq_fast), 32'(|vf));
            rd(A_VN, r);  check("R4 normal view", r, vn);
            rd(A_VF, r);  check("R4 fast view", r, vf);
            rd(A_RAW, r); check("R1 raw pending", r, s);
            rd(A_EN, r);  check("R5 enable", r, e);
            rd(A_RT, r);  check("R5 route", r, t);
        end

        // R1: no latching after a one-cycle pulse
        wr(A_EN, '1);
        wr(A_RT, '0);
        @(negedge clk); src_in = 32'h0000_0100;
        @(negedge clk); src_in = '0;
        #1; check("R1 pulse seen", 32'(irq_normal), 1);
        @(negedge clk); #1;
        check("R1 pulse dropped", 32'(irq_normal), 0);
        rd(A_RAW, r); check("R1 raw cleared", r, 0);

        // R6: idle flag
        wr(A_IDLE, 32'h0000_0001); rd(A_IDLE, r); check("R6 idle set", r, 1);
        wr(A_IDLE, 32'hFFFF_FFFE); rd(A_IDLE, r); check("R6 idle clear", r, 0);
        wr(A_IDLE, 32'h0000_0003); rd(A_IDLE, r); check("R6 idle set again", r, 1);

        // R9: unmapped reads and ignored writes
        wr(A_EN, 32'h1357_9BDF);
        wr(A_RT, 32'h2468_ACE0);
        rd(6, r); check("R9 read 6", r, 0);
        rd(7, r); check("R9 read 7", r, 0);
        wr(6, '1); wr(7, 32'h0); wr(A_RAW, '0); wr(A_VN, '1); wr(A_VF, '0);
        rd(A_EN, r);   check("R9 enable kept", r, 32'h1357_9BDF);
        rd(A_RT, r);   check("R9 route kept", r, 32'h2468_ACE0);
        rd(A_IDLE, r); check("R9 idle kept", r, 1);

        // R7: request change and mask write on the same edge
        wr(A_EN, '0);
        wr(A_RT, '0);
        set_src('0);
        @(negedge clk);
        src_in = 32'h0000_0010;
        bus_we = 1'b1; bus_addr = 3'(A_EN); bus_wdata = 32'h0000_0010;
        #1;
        check("R7 normal before edge", 32'(irq_normal), 0);
        check("R7 fast before edge", 32'(irq_fast), 0);
        @(posedge clk); #1;
        bus_we = 1'b0;
        check("R7 normal after edge", 32'(irq_normal), 1);
        check("R7 fast after edge", 32'(irq_fast), 0);
        // R7: one routing write moves the source between lines
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(A_RT); bus_wdata = 32'h0000_0010;
        #1;
        check("R7 normal held", 32'(irq_normal), 1);
        @(posedge clk); #1;
        bus_we = 1'b0;
        check("R7 normal moved", 32'(irq_normal), 0);
        check("R7 fast moved", 32'(irq_fast), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule